// File: doc/BRIEF.md
# Multi-Channel DCO Step Controller

This block holds one frequency word for each of several output synthesizer channels, together with a per-channel step word. An increment event adds each selected channel's own step word to its frequency word; a decrement event subtracts it. Events come either from two external pins (increment and decrement) or from a command written on a simple register write port. A channel-select mask decides which channels take part, so one event can move any subset of channels together, or a single channel on its own.

The event is gated by the loop operating state. Only the free-run and locked states accept steps. A request made in any other state, or a request that asks for increment and decrement at once, changes nothing and pulses a rejected flag. Frequency words saturate at configured limits instead of wrapping. The register port can also load a channel's frequency word or step word directly. A direct word load wins over a step on the same channel in the same cycle.

Top module: `dco_step_ctrl`

## Requirements
- R1: An accepted increment sets each masked channel's word to word + step, clamped to WORD_MAX.
- R2: An accepted decrement sets each masked channel's word to word - step, clamped to WORD_MIN.
- R3: Channels whose ch_mask bit is 0 keep their word on any step event. Any mask pattern, from one bit to all bits, is honoured.
- R4: Each pin passes through a two-flop synchronizer and acts only on its rising edge. The word changes on the third rising clock edge after the pin goes high. Holding the pin high gives exactly one step.
- R5: A write with wr_addr[1:0]=2 is a step command: wr_data[0] requests increment and wr_data[1] requests decrement. It acts on the clock edge that samples the write. A write with wr_addr[1:0]=3 has no effect.
- R6: If increment and decrement are both requested in the same cycle (from pins, the register port, or both), no word changes and rejected is high for the following cycle.
- R7: loop_state 0 (free-run) and 1 (locked) accept steps. With loop_state 2 or 3, a request changes no word and rejected is high for the following cycle.
- R8: A write with wr_addr[1:0]=0 loads channel wr_addr[ADDR_W-1:2]'s word with wr_data clamped to [WORD_MIN, WORD_MAX]. A write with wr_addr[1:0]=1 loads that channel's step word from wr_data[STEP_W-1:0]. Loads ignore loop_state, and a word load takes priority over a step on that channel in the same cycle.
- R9: After synchronous reset, every word equals WORD_RESET, every step word equals STEP_RESET, and rejected is 0.
- R10: rejected is 0 in any cycle that does not follow a conflicting or mode-gated request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_pin | input | 1 | Asynchronous increment pin |
| dec_pin | input | 1 | Asynchronous decrement pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | {channel, kind}; kind in bits [1:0] |
| wr_data | input | WORD_W | Write data |
| ch_mask | input | NUM_CH | Channels taking part in step events |
| loop_state | input | 2 | 0 free-run, 1 locked, 2 acquiring, 3 holdover |
| freq_words | output | NUM_CH*WORD_W | Channel c word at [c*WORD_W +: WORD_W] |
| rejected | output | 1 | Pulse for a refused step request |

## Verification
The bench builds the block with four channels, 12-bit words, 8-bit steps and limits of 16 and 4000. With these values, one step of up to 255 reaches either clamp from a word loaded near it, and every mask pattern can be drawn at random. The narrow word also lets an over-range load (4095) and an under-range load (0) test the load clamp directly. Together these bring both saturation paths and all sixteen subsets within reach in a few hundred random operations.

// File: rtl/dco_step_pkg.sv
package dco_step_pkg;
  typedef enum logic [1:0] {
    LOOP_FREERUN  = 2'd0,
    LOOP_LOCKED   = 2'd1,
    LOOP_ACQUIRE  = 2'd2,
    LOOP_HOLDOVER = 2'd3
  } loop_state_e;

  typedef enum logic [1:0] {
    WR_WORD = 2'd0,
    WR_STEP = 2'd1,
    WR_CMD  = 2'd2,
    WR_NONE = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/dco_pin_edge.sv
module dco_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise_pulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], pin};
  end

  // Pulse when the last synchronized stage is high and its delayed copy is low.
  assign rise_pulse = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse); // R4
endmodule

// File: rtl/dco_req_arbiter.sv
module dco_req_arbiter
  import dco_step_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_inc,
  input  logic       pin_dec,
  input  logic       cmd_inc,
  input  logic       cmd_dec,
  input  logic [1:0] loop_state,
  output logic       apply_inc,
  output logic       apply_dec,
  output logic       rejected
);
  logic inc_req, dec_req, any_req, mode_ok, conflict, refuse;

  always_comb begin
    inc_req  = pin_inc | cmd_inc;
    dec_req  = pin_dec | cmd_dec;
    any_req  = inc_req | dec_req;
    mode_ok  = (loop_state == LOOP_FREERUN) || (loop_state == LOOP_LOCKED);
    conflict = inc_req & dec_req;
    refuse   = any_req & (conflict | ~mode_ok);
    apply_inc = inc_req & ~dec_req & mode_ok;
    apply_dec = dec_req & ~inc_req & mode_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) rejected <= 1'b0;
    else     rejected <= refuse;
  end

  AST_CONFLICT_REJECT: assert property (@(posedge clk) disable iff (rst)
    (inc_req && dec_req) |=> rejected); // R6
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({apply_inc, apply_dec})); // R6
  AST_GATE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (any_req && loop_state[1]) |=> rejected); // R7
  AST_GATE_NO_APPLY: assert property (@(posedge clk) disable iff (rst)
    loop_state[1] |-> !(apply_inc || apply_dec)); // R7
  AST_QUIET_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
    !any_req |=> !rejected); // R10
endmodule

// File: rtl/dco_chan_word.sv
module dco_chan_word #(
  parameter int          WORD_W     = 16,
  parameter int          STEP_W     = 8,
  parameter int unsigned WORD_MIN   = 16,
  parameter int unsigned WORD_MAX   = 65000,
  parameter int unsigned WORD_RESET = 32768,
  parameter int unsigned STEP_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              apply_inc,
  input  logic              apply_dec,
  input  logic              ld_word,
  input  logic              ld_step,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q
);
  localparam int XW = WORD_W + 2;
  localparam logic [WORD_W-1:0] MIN_W = WORD_W'(WORD_MIN);
  localparam logic [WORD_W-1:0] MAX_W = WORD_W'(WORD_MAX);
  localparam logic [XW-1:0]     MIN_X = XW'(WORD_MIN);
  localparam logic [XW-1:0]     MAX_X = XW'(WORD_MAX);

  logic [STEP_W-1:0] step_q;
  logic [XW-1:0]     word_x, step_x, up_x, floor_x;
  logic [WORD_W-1:0] up_w, dn_w, ld_w, word_d;

  always_comb begin
    word_x  = XW'(word_q);
    step_x  = XW'(step_q);
    up_x    = word_x + step_x;
    floor_x = MIN_X + step_x;
    up_w = (up_x > MAX_X) ? MAX_W : up_x[WORD_W-1:0];
    dn_w = (word_x < floor_x) ? MIN_W : (word_q - WORD_W'(step_q));
    if (wr_data < MIN_W)      ld_w = MIN_W;
    else if (wr_data > MAX_W) ld_w = MAX_W;
    else                      ld_w = wr_data;

    if (ld_word)                word_d = ld_w;
    else if (sel && apply_inc)  word_d = up_w;
    else if (sel && apply_dec)  word_d = dn_w;
    else                        word_d = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= WORD_W'(WORD_RESET);
      step_q <= STEP_W'(STEP_RESET);
    end else begin
      word_q <= word_d;
      if (ld_step) step_q <= wr_data[STEP_W-1:0];
    end
  end

  AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (word_q >= MIN_W) && (word_q <= MAX_W)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ld_word && !(sel && (apply_inc || apply_dec))) |=> $stable(word_q)); // R3
  AST_INC_RISES: assert property (@(posedge clk) disable iff (rst)
    (sel && apply_inc && !ld_word) |=> (word_q >= $past(word_q))); // R1
  AST_DEC_FALLS: assert property (@(posedge clk) disable iff (rst)
    (sel && apply_dec && !ld_word) |=> (word_q <= $past(word_q))); // R2
endmodule

// File: rtl/dco_step_ctrl.sv
module dco_step_ctrl
  import dco_step_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter int          WORD_W     = 16,
  parameter int          STEP_W     = 8,
  parameter int unsigned WORD_MIN   = 16,
  parameter int unsigned WORD_MAX   = 65000,
  parameter int unsigned WORD_RESET = 32768,
  parameter int unsigned STEP_RESET = 1,
  parameter int          CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int          ADDR_W     = CH_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inc_pin,
  input  logic                     dec_pin,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        ch_mask,
  input  logic [1:0]               loop_state,
  output logic [NUM_CH*WORD_W-1:0] freq_words,
  output logic                     rejected
);
  logic       pin_inc_evt, pin_dec_evt;
  logic       cmd_inc, cmd_dec;
  logic       apply_inc, apply_dec;
  logic [1:0] wr_kind;
  logic [CH_W-1:0] wr_ch;

  assign wr_kind = wr_addr[1:0];
  assign wr_ch   = wr_addr[ADDR_W-1:2];
  assign cmd_inc = wr_en && (wr_kind == WR_CMD) && wr_data[0];
  assign cmd_dec = wr_en && (wr_kind == WR_CMD) && wr_data[1];

  dco_pin_edge #(.SYNC_STAGES(2)) u_inc_edge (
    .clk(clk), .rst(rst), .pin(inc_pin), .rise_pulse(pin_inc_evt));
  dco_pin_edge #(.SYNC_STAGES(2)) u_dec_edge (
    .clk(clk), .rst(rst), .pin(dec_pin), .rise_pulse(pin_dec_evt));

  dco_req_arbiter u_arb (
    .clk(clk), .rst(rst),
    .pin_inc(pin_inc_evt), .pin_dec(pin_dec_evt),
    .cmd_inc(cmd_inc), .cmd_dec(cmd_dec),
    .loop_state(loop_state),
    .apply_inc(apply_inc), .apply_dec(apply_dec),
    .rejected(rejected));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ld_word, ld_step;
    assign ld_word = wr_en && (wr_kind == WR_WORD) && (wr_ch == CH_W'(c));
    assign ld_step = wr_en && (wr_kind == WR_STEP) && (wr_ch == CH_W'(c));

    dco_chan_word #(
      .WORD_W(WORD_W), .STEP_W(STEP_W),
      .WORD_MIN(WORD_MIN), .WORD_MAX(WORD_MAX),
      .WORD_RESET(WORD_RESET), .STEP_RESET(STEP_RESET)
    ) u_word (
      .clk(clk), .rst(rst),
      .sel(ch_mask[c]),
      .apply_inc(apply_inc), .apply_dec(apply_dec),
      .ld_word(ld_word), .ld_step(ld_step),
      .wr_data(wr_data),
      .word_q(freq_words[c*WORD_W +: WORD_W]));
  end
endmodule

// File: tb/dco_step_ctrl_bench.sv
module dco_step_ctrl_bench;
  localparam int NCH = 4;
  localparam int WW = 12;
  localparam int SW = 8;
  localparam int WMIN = 16;
  localparam int WMAX = 4000;
  localparam int WRST = 2048;
  localparam int SRST = 1;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_pin = 1'b0, dec_pin = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [NCH-1:0] ch_mask = '0;
  logic [1:0] loop_state = 2'd0;
  logic [NCH*WW-1:0] freq_words;
  logic rejected;

  int exp_w[NCH];
  int exp_s[NCH];
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dco_step_ctrl #(
    .NUM_CH(NCH), .WORD_W(WW), .STEP_W(SW), .WORD_MIN(WMIN), .WORD_MAX(WMAX),
    .WORD_RESET(WRST), .STEP_RESET(SRST)
  ) u_dco_step_ctrl (
    .clk(clk), .rst(rst), .inc_pin(inc_pin), .dec_pin(dec_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ch_mask(ch_mask),
    .loop_state(loop_state), .freq_words(freq_words), .rejected(rejected));

  function automatic int sat_up(int w, int s);
    return (w + s > WMAX) ? WMAX : w + s;
  endfunction
  function automatic int sat_dn(int w, int s);
    return (w - s < WMIN) ? WMIN : w - s;
  endfunction
  function automatic int clamp(int d);
    if (d < WMIN) return WMIN;
    if (d > WMAX) return WMAX;
    return d;
  endfunction

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(string req, int exp_rej);
    for (int c = 0; c < NCH; c++)
      check(req, int'(freq_words[c*WW +: WW]), exp_w[c]);
    check(req, int'(rejected), exp_rej);
  endtask

  // Model of one step event (R1 R2 R3 R6 R7); returns expected reject.
  function automatic int model_step(bit inc, bit dec, logic [NCH-1:0] m, logic [1:0] ls);
    if (!inc && !dec) return 0;
    if ((inc && dec) || ls > 2'd1) return 1;
    for (int c = 0; c < NCH; c++)
      if (m[c]) exp_w[c] = inc ? sat_up(exp_w[c], exp_s[c]) : sat_dn(exp_w[c], exp_s[c]);
    return 0;
  endfunction

  // Drive one write at a negedge; returns at the next negedge.
  task automatic wr(int kind, int ch, int data);
    wr_en = 1'b1;
    wr_addr = {2'(ch), 2'(kind)};
    wr_data = WW'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int r;
    for (int c = 0; c < NCH; c++) begin exp_w[c] = WRST; exp_s[c] = SRST; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R9 reset", 0);

    // R8 step loads, then R1/R5 increment on all channels
    for (int c = 0; c < NCH; c++) begin wr(1, c, 10 * (c + 1)); exp_s[c] = 10 * (c + 1); end
    // default step of R9 seen through a step: none needed, loaded above
    ch_mask = 4'b1111;
    wr(2, 0, 1); r = model_step(1, 0, ch_mask, 0);
    check_all("R1 R5 inc all", r);

    // R2 R3 decrement a subset
    ch_mask = 4'b0101;
    wr(2, 3, 2); r = model_step(0, 1, ch_mask, 0);
    check_all("R2 R3 dec subset", r);

    // R5 kind 3 has no effect
    wr(3, 0, 3);
    check_all("R5 kind3 ignored", 0);

    // R4 pin sync timing on channel 1
    ch_mask = 4'b0010;
    inc_pin = 1'b1;
    @(negedge clk); check_all("R4 pin after 1 edge", 0);
    @(negedge clk); check_all("R4 pin after 2 edges", 0);
    @(negedge clk); r = model_step(1, 0, ch_mask, 0); check_all("R4 pin after 3 edges", r);
    repeat (5) @(negedge clk);
    check_all("R4 pin held single step", 0);
    inc_pin = 1'b0;
    repeat (4) @(negedge clk);
    // R4 decrement pin, locked state
    loop_state = 2'd1;
    dec_pin = 1'b1;
    repeat (3) @(negedge clk);
    r = model_step(0, 1, ch_mask, 1);
    check_all("R4 R7 dec pin locked", r);
    dec_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R6 conflict via register
    ch_mask = 4'b1111;
    wr(2, 0, 3); r = model_step(1, 1, ch_mask, 1);
    check_all("R6 conflict reject", r);
    @(negedge clk); check_all("R10 reject clears", 0);

    // R7 gated states
    loop_state = 2'd2;
    wr(2, 0, 1); r = model_step(1, 0, ch_mask, 2);
    check_all("R7 acquiring gated", r);
    loop_state = 2'd3;
    wr(2, 0, 2); r = model_step(0, 1, ch_mask, 3);
    check_all("R7 holdover gated", r);
    // R8 load works while gated
    wr(0, 2, 1234); exp_w[2] = 1234;
    check_all("R8 load in holdover", 0);
    loop_state = 2'd0;

    // R8 load priority over coincident pin step (channels 0,1)
    ch_mask = 4'b0011;
    inc_pin = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(0, 0, 1000);
    exp_w[0] = 1000; exp_w[1] = sat_up(exp_w[1], exp_s[1]);
    check_all("R8 load beats step", 0);
    inc_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 saturation, R8 load clamps
    wr(0, 0, 3990); exp_w[0] = 3990;
    wr(1, 0, 200);  exp_s[0] = 200;
    ch_mask = 4'b0001;
    wr(2, 0, 1); r = model_step(1, 0, ch_mask, 0);
    check("R1 clamp max", int'(freq_words[0 +: WW]), WMAX);
    wr(0, 1, 20); exp_w[1] = 20;
    ch_mask = 4'b0010;
    wr(2, 0, 2); r = model_step(0, 1, ch_mask, 0);
    check("R2 clamp min", int'(freq_words[WW +: WW]), WMIN);
    wr(0, 3, 4095); exp_w[3] = clamp(4095);
    wr(0, 2, 0);    exp_w[2] = clamp(0);
    check_all("R8 load clamp", 0);

    // Random mix (R1 R2 R3 R5 R6 R7 R8 R10)
    void'($urandom(32'd1357));
    for (int i = 0; i < 400; i++) begin
      int kind, ch, data;
      kind = int'($urandom_range(0, 5));
      ch = int'($urandom_range(0, NCH - 1));
      ch_mask = NCH'($urandom);
      loop_state = 2'($urandom_range(0, 3));
      if (kind >= 2) begin
        data = int'($urandom_range(0, 3));
        wr(2, ch, data);
        r = model_step(data[0], data[1], ch_mask, loop_state);
      end else if (kind == 0) begin
        data = int'($urandom_range(0, 4095));
        wr(0, ch, data); exp_w[ch] = clamp(data); r = 0;
      end else begin
        data = int'($urandom_range(0, 255));
        wr(1, ch, data); exp_s[ch] = data; r = 0;
      end
      check_all("R1 R2 R3 R6 R7 R8 random", r);
    end

    finished = 1'b1;
    finish_run();
  end
endmodule